// File: doc/BRIEF.md
# Two-Wire Converter Read Controller

This block is the host-side master for a delta-sigma converter that exposes only two wires: a serial clock driven by the host and one shared line that the converter uses both to signal that data is ready and to shift that data out. The host has no command wire. It tells the converter what to do only through how many clock pulses it sends and how long it holds the clock high.

A command carries a two-bit mode and a hold length. Once the command is accepted, the controller waits for the shared line to go low, up to a programmable timeout. It then clocks in 24 bits, most significant first, and presents the sign-extended result with a one-cycle strobe. It finishes with the pulse pattern that the mode asks for. A plain read adds one more pulse, which returns the line high. A calibrating read adds two more pulses, and the converter then recalibrates. A sleeping read holds the clock high for the programmed number of cycles and then drops it, which wakes the converter. The clock half-period is a parameter counted in system clocks. It must be chosen so that each phase is at least 80 ns and the serial clock stays at or below 5 MHz.

Top module: `adc2w_reader`

## Requirements
- R1: After reset, `adc_sclk`, `busy`, `sample_valid` and `rdy_timeout` are all low.
- R2: After a command is accepted, the first rising edge of `adc_sclk` comes only after `adc_rdy_dout` has been seen low through the input synchronizer.
- R3: The 24 bits are sampled on the falling edges of `adc_sclk` pulses 1 to 24, in order from the most significant bit down. The word appears on `sample_data`, sign-extended to OUT_W bits, with `sample_valid` high for exactly one cycle.
- R4: Mode 2'b00 (plain) issues exactly 25 `adc_sclk` pulses, and the clock then stays low while the controller is idle. Mode 2'b11 behaves as plain.
- R5: Mode 2'b01 (calibrate) issues exactly 26 pulses. The next command waits for the line to fall again before it clocks any data.
- R6: Mode 2'b10 (sleep) issues 24 pulses, then holds `adc_sclk` high for exactly `cmd_hold_cycles` system clocks (a value of 0 holds for one clock), then drives it low.
- R7: During a read, each high phase and each low phase of `adc_sclk` lasts exactly HALF_CYC system clocks.
- R8: If the line is not seen low within `ready_timeout` clocks of acceptance, `rdy_timeout` pulses for one cycle, no `adc_sclk` pulse is issued, and `busy` drops.
- R9: `cmd_start` while `busy` is high is ignored: the running pulse pattern and mode are unchanged, and no further command follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Command request, taken when idle |
| cmd_mode | input | 2 | 00 plain, 01 calibrate, 10 sleep, 11 plain |
| cmd_hold_cycles | input | CNT_W | Sleep hold length in system clocks |
| ready_timeout | input | CNT_W | Maximum wait for the ready indication, in system clocks |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_rdy_dout | input | 1 | Shared ready/data line from the converter |
| sample_data | output | OUT_W | Last sample, sign-extended |
| sample_valid | output | 1 | One-cycle strobe when `sample_data` is updated |
| busy | output | 1 | High from command acceptance until the sequence ends |
| rdy_timeout | output | 1 | One-cycle pulse when the ready wait expires |

## Verification
Assertions check three things on every cycle. Every serial clock phase inside a read has the exact half-period length. The pulse counter never goes past the total for the active mode. The hold phase keeps the clock high, the strobe and timeout pulses last one cycle, and a clock edge never starts from the wait state unless the synchronized line was low. Only the bench scenarios, driven against a behavioural converter, can show the rest. These are the data order and the sign extension of real words, the exact total pulse counts, the measured sleep hold length, and the fact that a read after calibration or wake-up waits for the new ready fall.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_CAL   = 2'b01,
    MODE_SLEEP = 2'b10,
    MODE_ALT   = 2'b11
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CLK  = 2'd2,
    ST_HOLD = 2'd3
  } seq_st_e;

  // Number of full clock pulses a command issues before it finishes.
  function automatic int unsigned pulse_total(rd_mode_e m, int unsigned nbits);
    case (m)
      MODE_CAL:   return nbits + 2;
      MODE_SLEEP: return nbits;
      default:    return nbits + 1;
    endcase
  endfunction

endpackage

// File: rtl/adc2w_sync.sv
module adc2w_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/adc2w_halfcnt.sv
module adc2w_halfcnt #(
  parameter int HALF_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_end
);

  localparam int HC_W = $clog2(HALF_CYC + 1);
  localparam logic [HC_W-1:0] LAST = HC_W'(HALF_CYC - 1);

  logic [HC_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + HC_W'(1);
  end

  assign half_end = run && (cnt == LAST);

  // R7
  halfcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/adc2w_capture.sv
module adc2w_capture #(
  parameter int DATA_W = 24,
  parameter int OUT_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             last_bit,
  input  logic             bit_in,
  output logic [OUT_W-1:0] word,
  output logic             valid
);

  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] next_sh;

  function automatic logic [OUT_W-1:0] sext(input logic [DATA_W-1:0] v);
    return OUT_W'($signed(v));
  endfunction

  assign next_sh = {sh[DATA_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (shift_en) begin
        sh <= next_sh;
        if (last_bit) begin
          word  <= sext(next_sh);
          valid <= 1'b1;
        end
      end
    end
  end

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

endmodule

// File: rtl/adc2w_seq.sv
module adc2w_seq
  import adc2w_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] hold_len,
  input  logic [CNT_W-1:0] tmo_limit,
  input  logic             rdy_s,
  input  logic             half_end,
  output logic             sclk,
  output logic             phase_run,
  output logic             shift_en,
  output logic             last_bit,
  output logic             busy,
  output logic             timeout
);

  localparam int PCNT_W = $clog2(DATA_W + 3);

  seq_st_e           st_q;
  rd_mode_e          mode_q;
  logic [CNT_W-1:0]  hold_q;
  logic [CNT_W-1:0]  lim_q;
  logic [CNT_W-1:0]  tmr;
  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] total;
  logic              sclk_q;
  logic              tmo_q;

  always_comb total = PCNT_W'(pulse_total(mode_q, DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_PLAIN;
      hold_q <= '0;
      lim_q  <= '0;
      tmr    <= '0;
      pcnt   <= '0;
      sclk_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      tmo_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          sclk_q <= 1'b0;
          if (start) begin
            mode_q <= rd_mode_e'(mode);
            hold_q <= hold_len;
            lim_q  <= tmo_limit;
            tmr    <= '0;
            st_q   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!rdy_s) begin
            st_q   <= ST_CLK;
            sclk_q <= 1'b1;
            pcnt   <= '0;
          end else if (tmr >= lim_q) begin
            tmo_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            tmr <= tmr + CNT_W'(1);
          end
        end
        ST_CLK: begin
          if (half_end) begin
            if (sclk_q) begin
              sclk_q <= 1'b0;
              pcnt   <= pcnt + PCNT_W'(1);
            end else if (pcnt == total) begin
              if (mode_q == MODE_SLEEP) begin
                st_q   <= ST_HOLD;
                sclk_q <= 1'b1;
                tmr    <= CNT_W'(1);
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              sclk_q <= 1'b1;
            end
          end
        end
        default: begin  // ST_HOLD
          if (tmr >= hold_q) begin
            sclk_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            tmr <= tmr + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign sclk      = sclk_q;
  assign busy      = (st_q != ST_IDLE);
  assign timeout   = tmo_q;
  assign phase_run = (st_q == ST_CLK);
  assign shift_en  = (st_q == ST_CLK) && half_end && sclk_q &&
                     (pcnt < PCNT_W'(DATA_W));
  assign last_bit  = shift_en && (pcnt == PCNT_W'(DATA_W - 1));

  // R2
  rise_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_q) && $past(st_q) == ST_WAIT) |-> !$past(rdy_s));

  // R4 R5 R6
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CLK) |-> (pcnt <= total));

  // R6
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |-> sclk_q);

  // R8
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (st_q == ST_IDLE && !sclk_q && !$past(sclk_q)));

  // R9
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start) |=> ($stable(mode_q) && $stable(hold_q)));

endmodule

// File: rtl/adc2w_reader.sv
module adc2w_reader #(
  parameter int HALF_CYC    = 25,
  parameter int DATA_W      = 24,
  parameter int OUT_W       = 32,
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_mode,
  input  logic [CNT_W-1:0] cmd_hold_cycles,
  input  logic [CNT_W-1:0] ready_timeout,
  output logic             adc_sclk,
  input  logic             adc_rdy_dout,
  output logic [OUT_W-1:0] sample_data,
  output logic             sample_valid,
  output logic             busy,
  output logic             rdy_timeout
);

  localparam int SW = $clog2(HALF_CYC + 2) + 1;

  logic rdy_s;
  logic half_end;
  logic phase_run;
  logic shift_en;
  logic last_bit;

  adc2w_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (adc_rdy_dout),
    .dout (rdy_s)
  );

  adc2w_halfcnt #(.HALF_CYC(HALF_CYC)) u_half (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (phase_run),
    .half_end(half_end)
  );

  adc2w_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_start),
    .mode     (cmd_mode),
    .hold_len (cmd_hold_cycles),
    .tmo_limit(ready_timeout),
    .rdy_s    (rdy_s),
    .half_end (half_end),
    .sclk     (adc_sclk),
    .phase_run(phase_run),
    .shift_en (shift_en),
    .last_bit (last_bit),
    .busy     (busy),
    .timeout  (rdy_timeout)
  );

  adc2w_capture #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .last_bit(last_bit),
    .bit_in  (rdy_s),
    .word    (sample_data),
    .valid   (sample_valid)
  );

  // Phase-length checker: cycles since the last serial clock toggle.
  logic          sclk_d;
  logic [SW-1:0] since;
  logic          lvl_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      since  <= '0;
      lvl_ok <= 1'b0;
    end else begin
      sclk_d <= adc_sclk;
      if (adc_sclk != sclk_d) begin
        since  <= '0;
        lvl_ok <= phase_run;
      end else begin
        if (since != {SW{1'b1}}) since <= since + SW'(1);
        lvl_ok <= lvl_ok && phase_run;
      end
    end
  end

  // R7
  phase_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk != sclk_d && lvl_ok) |-> (since == SW'(HALF_CYC - 1)));

  // R3
  valid_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> busy);

endmodule

// File: tb/adc2w_reader_test.sv
module adc2w_reader_test;

  localparam int HALF   = 25;
  localparam int DW     = 24;
  localparam int OW     = 32;
  localparam int CW     = 20;
  localparam int SLP_DET = 3 * HALF;
  localparam int CONV_Q = 150;
  localparam int CAL_Q  = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_start = 1'b0;
  logic [1:0]    cmd_mode = 2'b00;
  logic [CW-1:0] cmd_hold_cycles = '0;
  logic [CW-1:0] ready_timeout = CW'(5000);
  logic          adc_sclk;
  logic          adc_rdy_dout;
  logic [OW-1:0] sample_data;
  logic          sample_valid;
  logic          busy;
  logic          rdy_timeout;

  always #2 clk = ~clk;

  adc2w_reader #(.HALF_CYC(HALF), .DATA_W(DW), .OUT_W(OW), .CNT_W(CW)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_start      (cmd_start),
    .cmd_mode       (cmd_mode),
    .cmd_hold_cycles(cmd_hold_cycles),
    .ready_timeout  (ready_timeout),
    .adc_sclk       (adc_sclk),
    .adc_rdy_dout   (adc_rdy_dout),
    .sample_data    (sample_data),
    .sample_valid   (sample_valid),
    .busy           (busy),
    .rdy_timeout    (rdy_timeout)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] samp(input int i);
    case (i % 8)
      0: return 24'h7FFFFF;
      1: return 24'h800000;
      2: return 24'h000000;
      3: return 24'hFFFFFF;
      4: return 24'h5A5A5A;
      5: return 24'hA5A5A5;
      6: return 24'h000001;
      default: return 24'h812345;
    endcase
  endfunction

  // Sign extension restated as bit replication.
  function automatic logic [OW-1:0] widen(input logic [DW-1:0] v);
    logic [OW-1:0] r;
    for (int b = 0; b < OW; b++) r[b] = (b < DW) ? v[b] : v[DW-1];
    return r;
  endfunction

  // ---------------- converter model ----------------
  logic m_dout = 1'b1;
  bit   m_stall = 1'b0;
  assign adc_rdy_dout = m_dout;

  initial begin
    int  cnt = 0, quiet = 0, hrun = 0, idx = 0, state = 0;
    bit  prev = 1'b0, cal = 1'b0;
    logic [DW-1:0] cur = '0;
    forever begin
      @(posedge clk);
      if (adc_sclk != prev) quiet = 0;
      else if (quiet < 100000) quiet++;
      if (adc_sclk && !prev) begin
        cnt++;
        if (cnt <= DW) m_dout <= cur[DW-cnt];
        else m_dout <= 1'b1;
        if (cnt == DW + 2) cal = 1'b1;
        if (cnt >= DW + 1 && state != 2) state = 0;
      end
      hrun = adc_sclk ? hrun + 1 : 0;
      if (hrun > SLP_DET && state != 2) begin
        state = 2;
        m_dout <= 1'b1;
      end
      if (!adc_sclk && prev && state == 2) state = 0;
      if (state == 0 && !adc_sclk && !m_stall &&
          quiet >= CONV_Q + (cal ? CAL_Q : 0)) begin
        cur = samp(idx);
        idx++;
        m_dout <= 1'b0;
        cnt = 0;
        cal = 1'b0;
        state = 1;
      end
      prev = adc_sclk;
    end
  end

  // ---------------- monitor ----------------
  logic [OW-1:0] exp_q[$];
  int  rises = 0, first_high = 0, last_high = 0, cur_high = 0, tmo_cnt = 0, tmo_cyc = 0;
  bit  first_rdy_low = 1'b0;
  bit  mprev = 1'b0;
  logic rdy_prev = 1'b1;

  initial begin
    forever begin
      @(negedge clk);
      if (sample_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected sample_valid", sample_data, 0);
        end else begin
          logic [OW-1:0] e;
          e = exp_q.pop_front();
          check(sample_data == e, "R3 sample word", sample_data, e);
        end
      end
      if (rdy_timeout) begin
        tmo_cnt++;
        tmo_cyc = cyc;
      end
      if (adc_sclk && !mprev) begin
        if (rises == 0) first_rdy_low = !rdy_prev;
        rises++;
      end
      if (adc_sclk) cur_high++;
      if (!adc_sclk && mprev) begin
        last_high = cur_high;
        if (first_high == 0) first_high = cur_high;
        cur_high = 0;
      end
      mprev = adc_sclk;
      rdy_prev = adc_rdy_dout;
    end
  end

  // ---------------- driver ----------------
  int next_idx = 0;

  task automatic issue(input logic [1:0] mode, input int hold, input int lim, input bit want);
    @(negedge clk);
    rises = 0; first_high = 0; last_high = 0; first_rdy_low = 1'b0;
    if (want) begin
      exp_q.push_back(widen(samp(next_idx)));
      next_idx++;
    end
    cmd_mode = mode;
    cmd_hold_cycles = CW'(hold);
    ready_timeout = CW'(lim);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(adc_sclk == 1'b0, "R1 sclk low in reset", adc_sclk, 0);
    check(busy == 1'b0, "R1 busy low in reset", busy, 0);
    check(sample_valid == 1'b0, "R1 valid low in reset", sample_valid, 0);
    check(rdy_timeout == 1'b0, "R1 timeout low in reset", rdy_timeout, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(adc_sclk == 1'b0 && busy == 1'b0, "R1 idle after reset", {adc_sclk, busy}, 0);

    // Plain reads: positive and negative full scale
    issue(2'b00, 0, 5000, 1'b1);
    wait_idle();
    check(rises == 25, "R4 plain pulse count", rises, 25);
    check(first_rdy_low, "R2 first edge after ready low", first_rdy_low, 1);
    check(first_high == HALF, "R7 high phase length", first_high, HALF);
    check(adc_sclk == 1'b0, "R4 sclk idles low", adc_sclk, 0);
    issue(2'b11, 0, 5000, 1'b1);
    wait_idle();
    check(rises == 25, "R4 mode 11 acts as plain", rises, 25);

    // Calibrating read, then a read that must wait for the new ready fall
    issue(2'b01, 0, 5000, 1'b1);
    wait_idle();
    check(rises == 26, "R5 calibrate pulse count", rises, 26);
    issue(2'b00, 0, 5000, 1'b1);
    wait_idle();
    check(first_rdy_low, "R5 read after calibration waits for ready", first_rdy_low, 1);
    check(rises == 25, "R5 following plain read count", rises, 25);

    // Sleeping read
    issue(2'b10, 400, 5000, 1'b1);
    wait_idle();
    check(rises == 25, "R6 sleep: 24 pulses plus hold", rises, 25);
    check(last_high == 400, "R6 hold length", last_high, 400);
    check(adc_sclk == 1'b0, "R6 sclk low after wake", adc_sclk, 0);
    issue(2'b00, 0, 5000, 1'b1);
    wait_idle();
    check(first_rdy_low && rises == 25, "R6 read after wake", rises, 25);

    // Start while busy is ignored
    issue(2'b00, 0, 5000, 1'b1);
    repeat (600) @(negedge clk);
    cmd_mode = 2'b10; cmd_hold_cycles = CW'(500); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_idle();
    check(rises == 25, "R9 pulse count unchanged", rises, 25);
    check(last_high == HALF, "R9 no sleep hold", last_high, HALF);
    repeat (100) @(negedge clk);
    check(busy == 1'b0 && rises == 25, "R9 no extra command", busy, 0);

    // Ready timeout
    m_stall = 1'b1;
    tmo_cnt = 0;
    t0 = cyc;
    issue(2'b00, 0, 300, 1'b0);
    wait_idle();
    repeat (3) @(negedge clk);
    check(tmo_cnt == 1, "R8 timeout pulse count", tmo_cnt, 1);
    check(tmo_cyc - t0 >= 300 && tmo_cyc - t0 <= 310, "R8 timeout delay", tmo_cyc - t0, 300);
    check(rises == 0, "R8 no sclk on timeout", rises, 0);
    check(busy == 1'b0, "R8 busy drops", busy, 0);
    m_stall = 1'b0;

    issue(2'b00, 0, 5000, 1'b1);
    wait_idle();
    check(rises == 25, "R4 read after timeout", rises, 25);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 all samples delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule